// File: doc/BRIEF.md
# Host Port Mailbox Register File

This block is the device-side register file behind a byte-wide parallel host port. The host exchanges single bytes with an internal processing core through two one-byte mailboxes: an inbound one that the host fills and the core drains, and an outbound one that the core fills and the host drains. A status register at its own address tells the host whether the inbound mailbox is still occupied, whether an outbound byte is waiting, and whether a host byte was lost because it arrived too early.

The core marks the final byte of each outgoing message. While a message is pending, an active-low interrupt line tells the host to come and read; it returns high once the host has taken the final byte. While the core reports boot mode, the interrupt line stays high no matter what the core pushes, and the host must poll the status register instead.

Host accesses are synchronous: each clock edge with select and read (or write) high counts as one access. Read data is driven combinationally during the access cycle, and any side effect of the access takes hold at the edge that closes it.

Top module: `host_mailbox`

## Requirements
- R1: After reset the status register reads 0x00, the interrupt line is high, the core push-ready output is high and the inbound-valid output is low.
- R2: A host write to address 2'b00 while the inbound busy flag is low loads the byte. From the next cycle the core sees it on its inbound data output, and inbound-valid is high.
- R3: The inbound busy flag is bit 2 of the status word, read at address 2'b01. It rises with an accepted host write and stays high until the core pulses pop. It is low from the cycle after that pop.
- R4: A host write to address 2'b00 while busy is high is dropped: the inbound byte is unchanged. The write sets a sticky overrun flag at status bit 0.
- R5: A host read of the status register returns the overrun flag as it stood, then clears it. The next status read shows bit 0 low.
- R6: A core push while the outbound-ready flag (status bit 1) is low stores the byte and sets that flag. A host read of address 2'b00 returns the byte and clears the flag.
- R7: While outbound-ready is high, the push-ready output is low and a core push is refused: a host read of 2'b00 still returns the earlier byte.
- R8: Outside boot mode, a push the block accepts makes the interrupt line low from the next cycle. It stays low until the host reads the byte that the core pushed with its last-byte flag set, and it is high from the cycle after that read.
- R9: While boot mode is high, the interrupt line is high, even while an outbound byte is waiting.
- R10: Host reads of addresses 2'b10 and 2'b11 return 0x00. Host writes to any address other than 2'b00 leave both mailboxes and the status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host select; qualifies read and write |
| host_rd | input | 1 | Host read request |
| host_wr | input | 1 | Host write request |
| host_addr | input | 2 | Register address: 00 mailbox, 01 status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid during the read cycle |
| host_irq_n | output | 1 | Active-low outgoing-message interrupt |
| core_in_data | output | 8 | Inbound mailbox byte |
| core_in_valid | output | 1 | Inbound byte waiting for the core |
| core_pop | input | 1 | Core consumes the inbound byte |
| core_push | input | 1 | Core offers an outbound byte |
| core_push_data | input | 8 | Outbound byte |
| core_push_last | input | 1 | Offered byte ends the message |
| core_push_ready | output | 1 | Outbound mailbox can take a byte |
| core_boot_mode | input | 1 | Boot mode; keeps the interrupt line high |

## Verification
The hardest case to reach is a refused core push. The outbound mailbox must already be full and the interrupt already low, and the rejected byte must then leave no trace. The bench pushes the first byte of a message, pushes a second byte without reading, and then reads the mailbox. It expects the first byte, then the status with the ready flag clear and the interrupt still low, because the last byte has not come yet. The overrun flag can be seen only in the one status read that clears it. So the bench queues two status reads back to back, with different expected values, right after the dropped host write.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  // status word bit positions
  localparam int unsigned STAT_OVR_BIT = 0;
  localparam int unsigned STAT_RDY_BIT = 1;
  localparam int unsigned STAT_BSY_BIT = 2;

  typedef enum logic [1:0] {
    REG_MBOX = 2'b00,
    REG_STAT = 2'b01,
    REG_RSV2 = 2'b10,
    REG_RSV3 = 2'b11
  } hreg_e;

  // low three status bits from the three flags
  function automatic logic [2:0] pack_status(input logic bsy, input logic rdy, input logic ovr);
    logic [2:0] s;
    s = '0;
    s[STAT_BSY_BIT] = bsy;
    s[STAT_RDY_BIT] = rdy;
    s[STAT_OVR_BIT] = ovr;
    return s;
  endfunction
endpackage

// File: rtl/hmb_inbox.sv
module hmb_inbox #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         pop,
  output logic [W-1:0] data,
  output logic         busy,
  output logic         overrun_set
);
  logic accept;
  logic pop_eff;

  assign accept      = wr_req & ~busy;
  assign overrun_set = wr_req & busy;
  assign pop_eff     = pop & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      busy <= 1'b0;
    end else begin
      if (accept) begin
        data <= wr_data;
        busy <= 1'b1;
      end else if (pop_eff) begin
        busy <= 1'b0;
      end
    end
  end

  // R2
  accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && (data == $past(wr_data)));
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !pop |=> busy);
  // R4
  drop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_set |=> $stable(data));
endmodule

// File: rtl/hmb_outbox.sv
module hmb_outbox #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         push_last,
  input  logic         take,
  output logic [W-1:0] data,
  output logic         last,
  output logic         full,
  output logic         push_ok
);
  logic take_eff;

  assign push_ok  = push & ~full;
  assign take_eff = take & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      last <= 1'b0;
      full <= 1'b0;
    end else begin
      if (push_ok) begin
        data <= push_data;
        last <= push_last;
        full <= 1'b1;
      end else if (take_eff) begin
        full <= 1'b0;
      end
    end
  end

  // R7
  refuse_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !take |=> full && $stable(data));
  // R6
  take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && full |=> !full);
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import hmb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_irq_n,
  output logic [DATA_W-1:0] core_in_data,
  output logic              core_in_valid,
  input  logic              core_pop,
  input  logic              core_push,
  input  logic [DATA_W-1:0] core_push_data,
  input  logic              core_push_last,
  output logic              core_push_ready,
  input  logic              core_boot_mode
);
  localparam int unsigned STAT_LSB_W = 3;

  // named internal events
  logic host_wr_mbox, host_rd_mbox, host_rd_stat, host_wr_other;
  logic in_busy, ovr_set, overrun;
  logic [DATA_W-1:0] out_data;
  logic out_last, out_full, push_ok, msg_done, pending;
  logic [DATA_W-1:0] stat_word;

  assign host_wr_mbox  = host_sel & host_wr & (host_addr == ADDR_W'(REG_MBOX));
  assign host_wr_other = host_sel & host_wr & (host_addr != ADDR_W'(REG_MBOX));
  assign host_rd_mbox  = host_sel & host_rd & (host_addr == ADDR_W'(REG_MBOX));
  assign host_rd_stat  = host_sel & host_rd & (host_addr == ADDR_W'(REG_STAT));

  hmb_inbox #(.W(DATA_W)) u_inbox (
    .clk(clk), .rst_n(rst_n),
    .wr_req(host_wr_mbox), .wr_data(host_wdata),
    .pop(core_pop), .data(core_in_data),
    .busy(in_busy), .overrun_set(ovr_set)
  );

  hmb_outbox #(.W(DATA_W)) u_outbox (
    .clk(clk), .rst_n(rst_n),
    .push(core_push), .push_data(core_push_data), .push_last(core_push_last),
    .take(host_rd_mbox), .data(out_data), .last(out_last),
    .full(out_full), .push_ok(push_ok)
  );

  assign core_in_valid   = in_busy;
  assign core_push_ready = ~out_full;
  assign msg_done        = host_rd_mbox & out_full & out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (ovr_set)           overrun <= 1'b1;
      else if (host_rd_stat) overrun <= 1'b0;
      if (push_ok && !core_boot_mode) pending <= 1'b1;
      else if (msg_done)               pending <= 1'b0;
    end
  end

  assign host_irq_n = ~(pending & ~core_boot_mode);

  always_comb begin
    stat_word = '0;
    stat_word[STAT_LSB_W-1:0] = pack_status(in_busy, out_full, overrun);
  end

  always_comb begin
    host_rdata = '0;
    if (host_sel && host_rd) begin
      case (host_addr)
        ADDR_W'(REG_MBOX): host_rdata = out_data;
        ADDR_W'(REG_STAT): host_rdata = stat_word;
        default:           host_rdata = '0;
      endcase
    end
  end

  // R5
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_stat && !ovr_set |=> !overrun);
  // R8
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> host_irq_n);
  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && !core_boot_mode |=> !host_irq_n || core_boot_mode);
  // R10
  other_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_other && !core_pop |=> $stable(core_in_data) && $stable(in_busy));
endmodule

// File: tb/host_mailbox_bench.sv
`timescale 1ns/1ps
module host_mailbox_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic host_sel, host_rd, host_wr;
  logic [1:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic host_irq_n;
  logic [7:0] core_in_data;
  logic core_in_valid, core_pop, core_push, core_push_last, core_push_ready, core_boot_mode;
  logic [7:0] core_push_data;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  host_mailbox u_host_mailbox (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq_n(host_irq_n),
    .core_in_data(core_in_data), .core_in_valid(core_in_valid), .core_pop(core_pop),
    .core_push(core_push), .core_push_data(core_push_data),
    .core_push_last(core_push_last), .core_push_ready(core_push_ready),
    .core_boot_mode(core_boot_mode)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // status word expectation: bit2 busy, bit1 out-ready, bit0 overrun
  function automatic logic [7:0] stat_of(input logic b, input logic r, input logic o);
    return {5'b0, b, r, o};
  endfunction

  // monitor: compares read data in the access cycle
  always @(negedge clk) begin
    if (rst_n && host_sel && host_rd) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL unexpected read: got %02h expected none", host_rdata);
      end else begin
        check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic hread(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    host_sel = 1; host_rd = 1; host_addr = a;
    @(posedge clk); #1;
    host_sel = 0; host_rd = 0;
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_sel = 0; host_wr = 0;
  endtask

  task automatic cpush(input logic [7:0] d, input logic lst);
    @(posedge clk); #1;
    core_push = 1; core_push_data = d; core_push_last = lst;
    @(posedge clk); #1;
    core_push = 0; core_push_last = 0;
  endtask

  task automatic cpop();
    @(posedge clk); #1;
    core_pop = 1;
    @(posedge clk); #1;
    core_pop = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; host_sel = 0; host_rd = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    core_pop = 0; core_push = 0; core_push_data = 0; core_push_last = 0; core_boot_mode = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    settle();
    // R1 reset state
    check("R1 irq_n", {7'b0, host_irq_n}, 8'h01);
    check("R1 push_ready", {7'b0, core_push_ready}, 8'h01);
    check("R1 in_valid", {7'b0, core_in_valid}, 8'h00);
    hread(2'b01, 8'h00, "R1 status");

    // R2 accepted write
    hwrite(2'b00, 8'h5A);
    settle();
    check("R2 in_valid", {7'b0, core_in_valid}, 8'h01);
    check("R2 in_data", core_in_data, 8'h5A);
    hread(2'b01, stat_of(1, 0, 0), "R3 busy in status");

    // R4 dropped write, R5 clear on read
    hwrite(2'b00, 8'h11);
    settle();
    check("R4 in_data kept", core_in_data, 8'h5A);
    hread(2'b01, stat_of(1, 0, 1), "R4 overrun set");
    hread(2'b01, stat_of(1, 0, 0), "R5 overrun cleared");

    // R3 busy holds until pop
    repeat (5) @(posedge clk);
    settle();
    check("R3 still busy", {7'b0, core_in_valid}, 8'h01);
    cpop();
    settle();
    check("R3 cleared by pop", {7'b0, core_in_valid}, 8'h00);
    hread(2'b01, stat_of(0, 0, 0), "R3 status after pop");

    // R10 other addresses
    hwrite(2'b01, 8'h22);
    hwrite(2'b11, 8'h33);
    settle();
    check("R10 in_valid", {7'b0, core_in_valid}, 8'h00);
    check("R10 in_data", core_in_data, 8'h5A);
    hread(2'b01, stat_of(0, 0, 0), "R10 status");
    hread(2'b10, 8'h00, "R10 addr2");
    hread(2'b11, 8'h00, "R10 addr3");

    // R6/R7/R8 outbound message
    cpush(8'hA1, 0);
    settle();
    check("R6 push_ready low", {7'b0, core_push_ready}, 8'h00);
    check("R8 irq low", {7'b0, host_irq_n}, 8'h00);
    hread(2'b01, stat_of(0, 1, 0), "R6 out ready");
    cpush(8'hB2, 1);
    settle();
    check("R7 push_ready low", {7'b0, core_push_ready}, 8'h00);
    hread(2'b00, 8'hA1, "R7 refused push kept first");
    settle();
    check("R6 push_ready back", {7'b0, core_push_ready}, 8'h01);
    check("R8 irq still low", {7'b0, host_irq_n}, 8'h00);
    hread(2'b01, stat_of(0, 0, 0), "R6 ready cleared");
    cpush(8'hC3, 1);
    settle();
    check("R8 irq low last", {7'b0, host_irq_n}, 8'h00);
    hread(2'b00, 8'hC3, "R6 last byte");
    settle();
    check("R8 irq released", {7'b0, host_irq_n}, 8'h01);

    // R9 boot mode
    core_boot_mode = 1;
    cpush(8'h44, 1);
    repeat (3) begin
      settle();
      check("R9 irq high in boot", {7'b0, host_irq_n}, 8'h01);
      @(posedge clk);
    end
    hread(2'b01, stat_of(0, 1, 0), "R9 byte waiting");
    hread(2'b00, 8'h44, "R9 byte read");
    settle();
    check("R9 irq high after", {7'b0, host_irq_n}, 8'h01);
    core_boot_mode = 0;

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule